// File: doc/BRIEF.md
# Multi-Mode Clock-Crossing Interface FIFO

This block sits between a transceiver-side clock domain and a fabric-side clock domain. It carries a parallel data word, a small control field and a per-word valid bit. A static `mode` input picks one of three behaviours:

- **Retime** is a one-register bypass for a shared clock.
- **Phase** is a free-running phase-compensation buffer for two clocks that run at the same frequency.
- **Elastic** is a flow-controlled buffer for two clocks that may be asynchronous and may run at different frequencies.

Write and read pointers cross between the domains as Gray code through two-flop synchronizers. Full and partial-full are computed on the write clock. Empty and partial-empty are computed on the read clock. Both partial thresholds can be reloaded at run time.

The write side is a valid/ready stream. In elastic mode, `s_ready` is low while the buffer is full. A source that drives `s_valid` against a low `s_ready` loses that word, and the loss is recorded in a sticky overflow bit. In the other two modes `s_ready` stays high and nothing is dropped.

The read side has no back-pressure on the block. `m_req` asks for one word per read-clock cycle. The word appears with `m_valid` one read-clock edge later. A request made while the buffer is empty returns nothing, and it sets a sticky underflow bit.

Top module: `xcvr_xclk_fifo`

## Requirements
- R1: After reset in elastic mode:
  - `fifo_empty` and `fifo_pempty` are 1.
  - `fifo_full`, `fifo_pfull`, `m_valid`, `ovf_sticky` and `udf_sticky` are 0.
  - `s_ready` is 1.
- R2: With `mode`=1 (retime), both clocks must be the same clock. `m_data`, `m_ctrl` and `m_valid` equal `s_data`, `s_ctrl` and `s_valid` sampled at the previous edge. `s_ready` is 1, and all four flags stay 0.
- R3: With `mode`=0 or 3 (phase):
  - A word is written on every write edge, and `s_valid` is stored as the word's valid bit.
  - Reading starts once the synchronized occupancy reaches 2. After that, one word is read per edge at a fixed latency, with `m_valid` equal to the stored valid bit.
  - The flags stay 0.
- R4: With `mode`=2 (elastic), a word is written when `s_valid` and `s_ready` are both high. A read happens when `m_req` is high and the buffer is not empty. Words leave in the order they were accepted, with `m_valid` high one read edge after the request.
- R5: In elastic mode, `fifo_full` rises after 2^`ADDR_W` accepted writes (16 by default), and `s_ready` is 0 while full.
- R6: In elastic mode, an `s_valid` while full is dropped and sets `ovf_sticky`. The stored contents are unchanged.
- R7: In elastic mode, `m_req` while empty leaves `m_valid` low and `m_data` holding its last value, and it sets `udf_sticky`.
- R8: `fifo_pfull` is 1 when write-side occupancy is at or above the partial-full threshold. The threshold resets to `PF_RST` (5).
- R9: `fifo_pempty` is 1 when read-side occupancy is at or below the partial-empty threshold. The threshold resets to `PE_RST` (2).
- R10: A write-clock pulse on `pf_thr_ld` loads `pf_thr`. A read-clock pulse on `pe_thr_ld` loads `pe_thr`. The new values take effect from then on.
- R11: In elastic mode, ordering and data integrity hold when the read clock is slower than, and unrelated to, the write clock.
- R12: The sticky overflow and underflow bits clear only on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side (transceiver) clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| rd_clk | input | 1 | Read-side (fabric) clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read domain |
| mode | input | 2 | 0/3 phase, 1 retime, 2 elastic; static |
| s_valid | input | 1 | Write word valid / write enable |
| s_ready | output | 1 | Write side can accept a word |
| s_data | input | DATA_W | Write data |
| s_ctrl | input | CTRL_W | Write control bits |
| m_req | input | 1 | Read request (read enable) |
| m_valid | output | 1 | Output word valid |
| m_data | output | DATA_W | Read data |
| m_ctrl | output | CTRL_W | Read control bits |
| pf_thr | input | THR_W | Partial-full threshold value |
| pf_thr_ld | input | 1 | Load `pf_thr` (write clock) |
| pe_thr | input | THR_W | Partial-empty threshold value |
| pe_thr_ld | input | 1 | Load `pe_thr` (read clock) |
| fifo_full | output | 1 | Full, write domain, elastic only |
| fifo_pfull | output | 1 | Partial-full, write domain, elastic only |
| fifo_empty | output | 1 | Empty, read domain, elastic only |
| fifo_pempty | output | 1 | Partial-empty, read domain, elastic only |
| ovf_sticky | output | 1 | Write attempted while full |
| udf_sticky | output | 1 | Read attempted while empty |

## Verification
Results that stay inside one domain are due at the next edge, and the bench samples them on the falling edge that follows:
- retime output;
- read data and `m_valid` after a request;
- `s_ready` and the sticky bits.

Flags that depend on the other domain's pointer move only after one pointer register and two synchronizer stages, so they settle three edges after the causing event. The bench waits four edges before checking them, and before issuing reads.

In phase mode the start-up latency is measured once. Every later word is then required to arrive at exactly that latency.

// File: rtl/xcf_pkg.sv
package xcf_pkg;
  typedef enum logic [1:0] {
    XM_PHASE   = 2'd0,
    XM_RETIME  = 2'd1,
    XM_ELASTIC = 2'd2,
    XM_PHASE2  = 2'd3
  } xcf_mode_e;
endpackage

// File: rtl/xcf_gray_sync.sv
// Two-flop synchronizer for a Gray-coded pointer; delivers the binary value.
module xcf_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= gray_in;
      s2 <= s1;
    end
  end

  always_comb begin
    bin_out[W-1] = s2[W-1];
    for (int i = W-2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ s2[i];
  end
endmodule

// File: rtl/xcf_wr_side.sv
module xcf_wr_side
  import xcf_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int THR_W  = 6,
  parameter int PF_RST = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xcf_mode_e         mode,
  input  logic              s_valid,
  input  logic [ADDR_W:0]   rbin_sync,
  input  logic [THR_W-1:0]  thr_in,
  input  logic              thr_ld,
  output logic              wr_do,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   wgray,
  output logic              s_ready,
  output logic              full,
  output logic              pfull,
  output logic              ovf
);
  localparam int CW   = ADDR_W + 1;
  localparam int CMPW = (THR_W > CW) ? THR_W : CW;
  localparam logic [CW-1:0] FULL_CNT = CW'(1) << ADDR_W;

  logic [CW-1:0]    wbin, wbin_nxt, wcount;
  logic [THR_W-1:0] thr_q;
  logic             elastic, retime, full_raw;

  assign elastic  = (mode == XM_ELASTIC);
  assign retime   = (mode == XM_RETIME);
  assign wcount   = wbin - rbin_sync;
  assign full_raw = (wcount == FULL_CNT);
  assign wr_do    = !retime && !full_raw && (elastic ? s_valid : 1'b1);
  assign wbin_nxt = wbin + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      thr_q <= THR_W'(PF_RST);
      ovf   <= 1'b0;
    end else begin
      if (wr_do) begin
        wbin  <= wbin_nxt;
        wgray <= (wbin_nxt >> 1) ^ wbin_nxt;
      end
      if (thr_ld) thr_q <= thr_in;
      if (elastic && s_valid && full_raw) ovf <= 1'b1;
    end
  end

  assign waddr   = wbin[ADDR_W-1:0];
  assign s_ready = elastic ? !full_raw : 1'b1;
  assign full    = elastic && full_raw;
  assign pfull   = elastic && (CMPW'(wcount) >= CMPW'(thr_q));
endmodule

// File: rtl/xcf_rd_side.sv
module xcf_rd_side
  import xcf_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int THR_W  = 6,
  parameter int PE_RST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xcf_mode_e         mode,
  input  logic              m_req,
  input  logic [ADDR_W:0]   wbin_sync,
  input  logic [THR_W-1:0]  thr_in,
  input  logic              thr_ld,
  output logic              rd_do,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rgray,
  output logic              empty,
  output logic              pempty,
  output logic              udf
);
  localparam int CW   = ADDR_W + 1;
  localparam int CMPW = (THR_W > CW) ? THR_W : CW;

  logic [CW-1:0]    rbin, rbin_nxt, rcount;
  logic [THR_W-1:0] thr_q;
  logic             elastic, phase, empty_raw, primed, started;

  assign elastic   = (mode == XM_ELASTIC);
  assign phase     = (mode == XM_PHASE) || (mode == XM_PHASE2);
  assign rcount    = wbin_sync - rbin;
  assign empty_raw = (rcount == '0);
  assign primed    = (rcount >= CW'(2));
  assign rbin_nxt  = rbin + CW'(1);

  always_comb begin
    if (elastic)    rd_do = m_req && !empty_raw;
    else if (phase) rd_do = !empty_raw && (started || primed);
    else            rd_do = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      thr_q   <= THR_W'(PE_RST);
      udf     <= 1'b0;
      started <= 1'b0;
    end else begin
      if (rd_do) begin
        rbin  <= rbin_nxt;
        rgray <= (rbin_nxt >> 1) ^ rbin_nxt;
      end
      if (thr_ld) thr_q <= thr_in;
      if (elastic && m_req && empty_raw) udf <= 1'b1;
      if (phase && primed) started <= 1'b1;
    end
  end

  assign raddr  = rbin[ADDR_W-1:0];
  assign empty  = elastic && empty_raw;
  assign pempty = elastic && (CMPW'(rcount) <= CMPW'(thr_q));
endmodule

// File: rtl/xcvr_xclk_fifo.sv
module xcvr_xclk_fifo
  import xcf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 4,
  parameter int ADDR_W = 4,
  parameter int THR_W  = 6,
  parameter int PF_RST = 5,
  parameter int PE_RST = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic [1:0]        mode,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic [CTRL_W-1:0] s_ctrl,
  input  logic              m_req,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  output logic [CTRL_W-1:0] m_ctrl,
  input  logic [THR_W-1:0]  pf_thr,
  input  logic              pf_thr_ld,
  input  logic [THR_W-1:0]  pe_thr,
  input  logic              pe_thr_ld,
  output logic              fifo_full,
  output logic              fifo_pfull,
  output logic              fifo_empty,
  output logic              fifo_pempty,
  output logic              ovf_sticky,
  output logic              udf_sticky
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = ADDR_W + 1;
  localparam int WORD  = 1 + CTRL_W + DATA_W;

  xcf_mode_e mode_e;
  assign mode_e = xcf_mode_e'(mode);

  logic              wr_do, rd_do;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [CW-1:0]     wgray, rgray, wbin_s, rbin_s;
  logic [WORD-1:0]   mem [DEPTH];
  logic [WORD-1:0]   rword;

  xcf_wr_side #(.ADDR_W(ADDR_W), .THR_W(THR_W), .PF_RST(PF_RST)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .mode(mode_e), .s_valid(s_valid),
    .rbin_sync(rbin_s), .thr_in(pf_thr), .thr_ld(pf_thr_ld),
    .wr_do(wr_do), .waddr(waddr), .wgray(wgray), .s_ready(s_ready),
    .full(fifo_full), .pfull(fifo_pfull), .ovf(ovf_sticky)
  );

  xcf_rd_side #(.ADDR_W(ADDR_W), .THR_W(THR_W), .PE_RST(PE_RST)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .mode(mode_e), .m_req(m_req),
    .wbin_sync(wbin_s), .thr_in(pe_thr), .thr_ld(pe_thr_ld),
    .rd_do(rd_do), .raddr(raddr), .rgray(rgray),
    .empty(fifo_empty), .pempty(fifo_pempty), .udf(udf_sticky)
  );

  xcf_gray_sync #(.W(CW)) u_w2r (.clk(rd_clk), .rst_n(rd_rst_n), .gray_in(wgray), .bin_out(wbin_s));
  xcf_gray_sync #(.W(CW)) u_r2w (.clk(wr_clk), .rst_n(wr_rst_n), .gray_in(rgray), .bin_out(rbin_s));

  // storage: valid bit, control, data
  always_ff @(posedge wr_clk) begin
    if (wr_do) mem[waddr] <= {s_valid, s_ctrl, s_data};
  end

  assign rword = mem[raddr];

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_ctrl  <= '0;
    end else if (mode_e == XM_RETIME) begin
      m_valid <= s_valid;
      m_data  <= s_data;
      m_ctrl  <= s_ctrl;
    end else if (rd_do) begin
      m_valid <= (mode_e == XM_ELASTIC) ? 1'b1 : rword[WORD-1];
      m_ctrl  <= rword[DATA_W +: CTRL_W];
      m_data  <= rword[DATA_W-1:0];
    end else begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xcf_chk.sv
module xcf_chk (
  input logic       wr_clk,
  input logic       wr_rst_n,
  input logic       rd_clk,
  input logic       rd_rst_n,
  input logic [1:0] mode,
  input logic       s_valid,
  input logic       s_ready,
  input logic       m_req,
  input logic       m_valid,
  input logic       fifo_full,
  input logic       fifo_pfull,
  input logic       fifo_empty,
  input logic       fifo_pempty,
  input logic       ovf_sticky,
  input logic       udf_sticky
);
  // R2
  wr_flags_quiet_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (mode != 2'd2) |-> !(fifo_full || fifo_pfull));

  // R3
  rd_flags_quiet_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (mode != 2'd2) |-> !(fifo_empty || fifo_pempty));

  // R5
  full_blocks_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    fifo_full |-> !s_ready);

  // R6
  ovf_sticky_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    ovf_sticky |=> ovf_sticky);

  // R12
  udf_sticky_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    udf_sticky |=> udf_sticky);

  // R7
  empty_read_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (mode == 2'd2 && fifo_empty && m_req) |=> !m_valid);

  // R2
  retime_valid_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (mode == 2'd1) |=> (m_valid == $past(s_valid)));
endmodule

bind xcvr_xclk_fifo xcf_chk u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
  .mode(mode), .s_valid(s_valid), .s_ready(s_ready), .m_req(m_req),
  .m_valid(m_valid), .fifo_full(fifo_full), .fifo_pfull(fifo_pfull),
  .fifo_empty(fifo_empty), .fifo_pempty(fifo_pempty),
  .ovf_sticky(ovf_sticky), .udf_sticky(udf_sticky)
);

// File: tb/sim_xcvr_xclk_fifo.sv
`timescale 1ns/1ps
module sim_xcvr_xclk_fifo;
  logic wclk = 0, sclk = 0, slow = 0;
  logic rclk;
  logic rst_n = 0;
  logic [1:0] mode = 2'd2;
  logic s_valid = 0, m_req = 0, pf_ld = 0, pe_ld = 0;
  logic [31:0] s_data = '0;
  logic [3:0]  s_ctrl = '0;
  logic [5:0]  pf_thr = '0, pe_thr = '0;
  logic s_ready, m_valid, ffull, fpfull, fempty, fpempty, ovf, udf;
  logic [31:0] m_data;
  logic [3:0]  m_ctrl;
  int total = 0, fails = 0;
  bit done = 0;

  always #5 wclk = ~wclk;
  always #13 sclk = ~sclk;
  assign rclk = slow ? sclk : wclk;

  xcvr_xclk_fifo u0 (
    .wr_clk(wclk), .wr_rst_n(rst_n), .rd_clk(rclk), .rd_rst_n(rst_n), .mode(mode),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_ctrl(s_ctrl),
    .m_req(m_req), .m_valid(m_valid), .m_data(m_data), .m_ctrl(m_ctrl),
    .pf_thr(pf_thr), .pf_thr_ld(pf_ld), .pe_thr(pe_thr), .pe_thr_ld(pe_ld),
    .fifo_full(ffull), .fifo_pfull(fpfull), .fifo_empty(fempty), .fifo_pempty(fpempty),
    .ovf_sticky(ovf), .udf_sticky(udf)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input bit use_slow);
    @(negedge wclk);
    rst_n = 0; mode = m; slow = use_slow;
    s_valid = 0; m_req = 0;
    repeat (4) @(negedge wclk);
    rst_n = 1;
    repeat (2) @(negedge wclk);
  endtask

  task automatic settle();
    repeat (4) @(negedge wclk);
    repeat (4) @(negedge rclk);
  endtask

  // waits for ready, then hands one word over
  task automatic push(input logic [31:0] d);
    @(negedge wclk);
    while (!s_ready) @(negedge wclk);
    s_valid = 1; s_data = d; s_ctrl = d[3:0];
    @(negedge wclk);
    s_valid = 0;
  endtask

  // drives valid regardless of ready
  task automatic push_raw(input logic [31:0] d);
    @(negedge wclk);
    s_valid = 1; s_data = d; s_ctrl = d[3:0];
    @(negedge wclk);
    s_valid = 0;
  endtask

  task automatic pop(input string req, input logic [31:0] exp);
    @(negedge rclk);
    m_req = 1;
    @(negedge rclk);
    m_req = 0;
    chk(m_valid === 1'b1, {req, " m_valid"}, m_valid, 1);
    chk(m_data === exp, {req, " m_data"}, m_data, exp);
    chk(m_ctrl === exp[3:0], {req, " m_ctrl"}, m_ctrl, exp[3:0]);
  endtask

  task automatic t_reset_state();
    do_reset(2'd2, 0);
    chk(fempty === 1, "R1 empty", fempty, 1);
    chk(fpempty === 1, "R1 pempty", fpempty, 1);
    chk(ffull === 0 && fpfull === 0, "R1 full/pfull", {ffull, fpfull}, 0);
    chk(m_valid === 0, "R1 m_valid", m_valid, 0);
    chk(s_ready === 1, "R1 s_ready", s_ready, 1);
    chk(ovf === 0 && udf === 0, "R1 sticky", {ovf, udf}, 0);
  endtask

  task automatic t_retime();
    do_reset(2'd1, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge wclk);
      s_valid = (i % 3) != 2; s_data = 32'hC0DE_0000 + i; s_ctrl = 4'(i + 7);
      @(negedge wclk);
      chk(m_data === 32'hC0DE_0000 + i, "R2 data", m_data, 32'hC0DE_0000 + i);
      chk(m_ctrl === 4'(i + 7), "R2 ctrl", m_ctrl, 4'(i + 7));
      chk(m_valid === ((i % 3) != 2), "R2 valid", m_valid, (i % 3) != 2);
      chk(s_ready === 1 && {ffull, fpfull, fempty, fpempty} === 4'b0, "R2 flags", {s_ready, ffull, fpfull, fempty, fpempty}, 5'b10000);
    end
    s_valid = 0;
  endtask

  task automatic t_phase();
    logic [31:0] hist [64];
    bit          vb   [64];
    int k = -1;
    @(negedge wclk);
    rst_n = 0; mode = 2'd0; slow = 0; m_req = 0;
    repeat (4) @(negedge wclk);
    hist[0] = 32'h5000_0000; vb[0] = 1;
    s_data = hist[0]; s_ctrl = 4'd0; s_valid = 1; rst_n = 1;
    for (int n = 1; n < 48; n++) begin
      @(negedge wclk);
      if (n == 16) begin
        for (int j = 1; j <= 10; j++) if (hist[n-j] === m_data) k = j;
        chk(k >= 2 && k <= 8, "R3 latency", k, 4);
      end
      if (n > 16 && k > 0) begin
        chk(m_data === hist[n-k], "R3 data", m_data, hist[n-k]);
        chk(m_valid === vb[n-k], "R3 valid bit", m_valid, vb[n-k]);
        chk({ffull, fpfull, fempty, fpempty} === 4'b0, "R3 flags", {ffull, fpfull, fempty, fpempty}, 0);
      end
      hist[n] = 32'h5000_0000 + n; vb[n] = (n % 4) != 3;
      s_data = hist[n]; s_ctrl = 4'(n); s_valid = vb[n];
    end
    s_valid = 0;
  endtask

  task automatic t_elastic_thresholds();
    do_reset(2'd2, 0);
    for (int i = 0; i < 5; i++) begin
      push(32'hA100 + i);
      settle();
      chk(fpfull === (i >= 4), "R8 pfull default", fpfull, i >= 4);
    end
    chk(fpempty === 0, "R9 pempty at 5", fpempty, 0);
    pop("R4", 32'hA100);
    pop("R4", 32'hA101);
    settle();
    chk(fpempty === 0, "R9 pempty at 3", fpempty, 0);
    pop("R4", 32'hA102);
    settle();
    chk(fpempty === 1, "R9 pempty at 2", fpempty, 1);
    // runtime reload
    @(negedge wclk);
    pf_thr = 6'd3; pf_ld = 1; pe_thr = 6'd4; pe_ld = 1;
    @(negedge wclk);
    pf_ld = 0; pe_ld = 0;
    settle();
    chk(fpfull === 0, "R10 pfull at 2 thr 3", fpfull, 0);
    push(32'hA105);
    settle();
    chk(fpfull === 1, "R10 pfull at 3 thr 3", fpfull, 1);
    chk(fpempty === 1, "R10 pempty at 3 thr 4", fpempty, 1);
    push(32'hA106);
    push(32'hA107);
    settle();
    chk(fpempty === 0, "R10 pempty at 5 thr 4", fpempty, 0);
    pop("R4", 32'hA103);
    pop("R4", 32'hA104);
    pop("R4", 32'hA105);
  endtask

  task automatic t_full_over_under();
    do_reset(2'd2, 0);
    for (int i = 0; i < 16; i++) push(32'hB000 + i);
    settle();
    chk(ffull === 1, "R5 full", ffull, 1);
    chk(s_ready === 0, "R5 s_ready", s_ready, 0);
    chk(ovf === 0, "R6 ovf before", ovf, 0);
    push_raw(32'hDEAD_BEEF);
    chk(ovf === 1, "R6 ovf set", ovf, 1);
    for (int i = 0; i < 16; i++) pop("R6 contents", 32'hB000 + i);
    settle();
    chk(fempty === 1, "R7 empty", fempty, 1);
    chk(udf === 0, "R7 udf before", udf, 0);
    @(negedge rclk);
    m_req = 1;
    @(negedge rclk);
    m_req = 0;
    chk(m_valid === 0, "R7 m_valid", m_valid, 0);
    chk(m_data === 32'hB00F, "R7 data held", m_data, 32'hB00F);
    chk(udf === 1, "R7 udf set", udf, 1);
    settle();
    chk(ovf === 1 && udf === 1, "R12 sticky held", {ovf, udf}, 2'b11);
    do_reset(2'd2, 0);
    chk(ovf === 0 && udf === 0, "R12 cleared by reset", {ovf, udf}, 0);
  endtask

  task automatic t_slow_read();
    do_reset(2'd2, 1);
    for (int i = 0; i < 12; i++) push(32'hE000 + 3 * i);
    settle();
    for (int i = 0; i < 12; i++) pop("R11", 32'hE000 + 3 * i);
    settle();
    chk(fempty === 1, "R11 drained", fempty, 1);
  endtask

  initial begin
    t_reset_state();
    t_retime();
    t_phase();
    t_elastic_thresholds();
    t_full_over_under();
    t_slow_read();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule